// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Codec

This block carries a one-bit level across a barrier that can only pass short events. The transmit half synchronizes its input, detects level changes and turns each change into a one-cycle pulse. A rising level goes out on the set line and a falling level on the clear line. While the input stays quiet, the transmitter repeats a pulse on the line that matches the present level once per refresh interval. A receiver that missed an edge therefore recovers the correct level within one interval.

The receive half is a pulse-driven bistable. A set pulse moves the output to its "one" level and a clear pulse moves it to its "zero" level; between pulses the output holds. A loss-of-pulse watchdog forces a fixed default output and raises a link-lost flag when the line falls silent. A set and a clear pulse in the same cycle are discarded and recorded on a sticky error flag. A parameter selects whether the output follows the input or its complement, as an inverting barrier path would give.

The two halves are exposed separately: the transmit pulse lines are outputs and the receive pulse lines are inputs. They are normally tied together; a test can break the loop to starve the receiver. All intervals are counted in clock cycles.

Top module: `pulse_iso_link`

## Requirements
- R1: A 0-to-1 change of `din` yields exactly one pulse on `tx_set_o` and none on `tx_clr_o`; a 1-to-0 change yields exactly one pulse on `tx_clr_o` and none on `tx_set_o`. The pulse is high in the cycle after the second rising edge following the edge that first samples the new `din` (two synchronizer stages plus the pulse register).
- R2: Every transmit pulse lasts exactly one clock cycle, and `tx_set_o` and `tx_clr_o` are never high together.
- R3: A lone pulse on `rx_set_i` makes `dout` equal to the set level one edge later; a lone pulse on `rx_clr_i` makes it equal to the clear level. With the loop closed, `dout` follows `din` three rising edges after `din` is first sampled. The set level is 1 and the clear level is 0 when `INVERT` is 0.
- R4: While `din` is steady, the transmitter repeats a pulse on the line matching the current level every `REFRESH_CYC` cycles, with a gap of exactly `REFRESH_CYC` cycles between pulse starts.
- R5: Every transmitted pulse, including an edge pulse, restarts the refresh count, so the next refresh follows an edge pulse by exactly `REFRESH_CYC` cycles.
- R6: If neither receive line pulses for `WDOG_CYC` consecutive cycles, `link_lost` rises and `dout` takes `DEFAULT_LVL`. Both take effect on the `WDOG_CYC`-th edge after the edge that captured the last pulse, and not earlier.
- R7: A lone receive pulse while `link_lost` is high clears `link_lost` and sets `dout` to the level that pulse encodes, one edge later.
- R8: A set and a clear pulse received in the same cycle leave `dout` unchanged and set `pulse_err`. Once set, `pulse_err` stays high until reset, even when later pulses are valid.
- R9: During and right after synchronous reset, `dout` = `DEFAULT_LVL`, `link_lost` = 1 and `pulse_err` = 0. After reset is released, the transmitter emits one pulse that encodes the synchronized `din`, in the cycle after the third rising edge.
- R10: With `INVERT` = 1, the set level is 0 and the clear level is 1, so `dout` is the complement of `din` in steady state.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Transmit data level, may be asynchronous |
| tx_set_o | output | 1 | Transmit pulse line for a high level |
| tx_clr_o | output | 1 | Transmit pulse line for a low level |
| rx_set_i | input | 1 | Receive pulse line for a high level |
| rx_clr_i | input | 1 | Receive pulse line for a low level |
| dout | output | 1 | Received data level |
| link_lost | output | 1 | High while the watchdog default is in force |
| pulse_err | output | 1 | Sticky flag for simultaneous set and clear pulses |

## Verification
Edge pulses are due two edges after `din` is first sampled, so each stimulus is held at least five cycles. Pulses are counted at every falling edge of that hold, and `dout` is read once the third edge has passed. Refresh spacing and the post-edge gap are measured with a falling-edge cycle counter, and must equal `REFRESH_CYC` exactly. For the watchdog, the loop is opened and one pulse is driven by hand. The falling edges until `link_lost` rises are then counted and must equal `WDOG_CYC`. Collision, recovery and reset outputs are read one falling edge after the driving rising edge.

// File: rtl/pulse_iso_pkg.sv
package pulse_iso_pkg;

    typedef struct packed {
        logic set;
        logic clr;
    } pulse_pair_t;

    function automatic pulse_pair_t encode_level(input logic lvl);
        pulse_pair_t p;
        p.set = lvl;
        p.clr = ~lvl;
        return p;
    endfunction

endpackage

// File: rtl/pulse_iso_tx.sv
module pulse_iso_tx
    import pulse_iso_pkg::*;
#(
    parameter int REFRESH_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic set_o,
    output logic clr_o
);
    localparam int CW = $clog2(REFRESH_CYC + 1);
    localparam logic [CW-1:0] REFRESH_LAST = CW'(REFRESH_CYC - 1);
    localparam logic [1:0] PRIME_EMIT = 2'd2;
    localparam logic [1:0] PRIME_RUN  = 2'd3;

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          lvl;
        logic [1:0]    prime;
        logic [CW-1:0] cnt;
        pulse_pair_t   pls;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.pls  = '0;
        if (st_q.prime == PRIME_RUN) begin
            if (st_q.sync != st_q.lvl) begin
                st_d.lvl = st_q.sync;
                st_d.pls = encode_level(st_q.sync);
                st_d.cnt = '0;
            end else if (st_q.cnt == REFRESH_LAST) begin
                st_d.pls = encode_level(st_q.lvl);
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.prime == PRIME_EMIT) begin
            st_d.lvl   = st_q.sync;
            st_d.pls   = encode_level(st_q.sync);
            st_d.cnt   = '0;
            st_d.prime = PRIME_RUN;
        end else begin
            st_d.lvl   = st_q.sync;
            st_d.prime = st_q.prime + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = st_q.pls.set;
    assign clr_o = st_q.pls.clr;

    assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(set_o && clr_o));
    assert_set_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        set_o |=> !set_o);
    assert_clr_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o);

endmodule

// File: rtl/pulse_iso_rx.sv
module pulse_iso_rx #(
    parameter int   WDOG_CYC    = 80,
    parameter bit   INVERT      = 1'b0,
    parameter logic DEFAULT_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic dout,
    output logic link_lost,
    output logic pulse_err
);
    localparam int CW = $clog2(WDOG_CYC + 1);
    localparam logic [CW-1:0] WDOG_LAST = CW'(WDOG_CYC - 1);
    localparam logic SET_LVL = INVERT ? 1'b0 : 1'b1;
    localparam logic CLR_LVL = ~SET_LVL;

    typedef struct packed {
        logic          out;
        logic          lost;
        logic          err;
        logic [CW-1:0] cnt;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      lone_pulse;
    logic      collision;

    assign lone_pulse = set_i ^ clr_i;
    assign collision  = set_i & clr_i;

    always_comb begin
        st_d = st_q;
        if (collision) begin
            st_d.err = 1'b1;
        end
        if (lone_pulse) begin
            st_d.out  = set_i ? SET_LVL : CLR_LVL;
            st_d.lost = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.lost) begin
            if (st_q.cnt == WDOG_LAST) begin
                st_d.lost = 1'b1;
                st_d.out  = DEFAULT_LVL;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.out  <= DEFAULT_LVL;
            st_q.lost <= 1'b1;
            st_q.err  <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.out;
    assign link_lost = st_q.lost;
    assign pulse_err = st_q.err;

    assert_set_takes_level_R3: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> (dout == SET_LVL));
    assert_clr_takes_level_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> (dout == CLR_LVL));
    assert_lost_forces_default_R6: assert property (@(posedge clk) disable iff (rst)
        link_lost |-> (dout == DEFAULT_LVL));
    assert_pulse_clears_lost_R7: assert property (@(posedge clk) disable iff (rst)
        (link_lost && (set_i ^ clr_i)) |=> !link_lost);
    assert_collision_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> ($stable(dout) && pulse_err));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_err |=> pulse_err);

endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link #(
    parameter int   REFRESH_CYC = 16,
    parameter int   WDOG_CYC    = 80,
    parameter bit   INVERT      = 1'b0,
    parameter logic DEFAULT_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tx_set_o,
    output logic tx_clr_o,
    input  logic rx_set_i,
    input  logic rx_clr_i,
    output logic dout,
    output logic link_lost,
    output logic pulse_err
);
    pulse_iso_tx #(
        .REFRESH_CYC(REFRESH_CYC)
    ) u_tx (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .set_o(tx_set_o),
        .clr_o(tx_clr_o)
    );

    pulse_iso_rx #(
        .WDOG_CYC   (WDOG_CYC),
        .INVERT     (INVERT),
        .DEFAULT_LVL(DEFAULT_LVL)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .set_i    (rx_set_i),
        .clr_i    (rx_clr_i),
        .dout     (dout),
        .link_lost(link_lost),
        .pulse_err(pulse_err)
    );

endmodule

// File: tb/sim_pulse_iso_link.sv
module sim_pulse_iso_link;
    localparam int REFRESH = 16;
    localparam int WDOG    = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic loop_on = 1'b1;
    logic bset = 1'b0;
    logic bclr = 1'b0;
    logic tset, tclr, dout, lost, perr;
    logic rset, rclr;
    logic i_set, i_clr, i_dout, i_lost, i_err;

    int checks = 0;
    int errors = 0;
    int cs = 0;
    int cc = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign rset = loop_on ? tset : bset;
    assign rclr = loop_on ? tclr : bclr;

    pulse_iso_link #(.REFRESH_CYC(REFRESH), .WDOG_CYC(WDOG), .INVERT(1'b0), .DEFAULT_LVL(1'b0)) u0 (
        .clk(clk), .rst(rst), .din(din), .tx_set_o(tset), .tx_clr_o(tclr),
        .rx_set_i(rset), .rx_clr_i(rclr), .dout(dout), .link_lost(lost), .pulse_err(perr));

    pulse_iso_link #(.REFRESH_CYC(REFRESH), .WDOG_CYC(WDOG), .INVERT(1'b1), .DEFAULT_LVL(1'b1)) u1 (
        .clk(clk), .rst(rst), .din(din), .tx_set_o(i_set), .tx_clr_o(i_clr),
        .rx_set_i(i_set), .rx_clr_i(i_clr), .dout(i_dout), .link_lost(i_lost), .pulse_err(i_err));

    // {din, hold cycles}; levels alternate so each entry is one edge
    localparam logic [4:0] VEC [8] = '{
        5'b0_0101, 5'b1_0110, 5'b0_1100, 5'b1_0101,
        5'b0_1000, 5'b1_1010, 5'b0_0111, 5'b1_1011
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            cs += int'(tset);
            cc += int'(tclr);
        end
    endtask

    task automatic next_pulse(output int at, output bit was_set);
        at = -1;
        was_set = 1'b0;
        for (int k = 0; k < 4 * REFRESH; k++) begin
            step(1);
            if (tset || tclr) begin
                at = cyc;
                was_set = tset;
                break;
            end
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0, t1, t2, k;
        bit s0, s1, s2;

        // R9: reset state and the first pulse after reset
        din = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dout == 1'b0, "R9 reset dout", int'(dout), 0);
        chk(lost == 1'b1, "R9 reset link_lost", int'(lost), 1);
        chk(perr == 1'b0, "R9 reset pulse_err", int'(perr), 0);
        cs = 0; cc = 0;
        step(5);
        chk(cs == 1 && cc == 0, "R9 boot pulse on set line", cs * 10 + cc, 10);
        chk(dout == 1'b1 && lost == 1'b0, "R9 boot level received", int'(dout) * 10 + int'(lost), 10);

        // R1, R3, R10: table of edges with loop closed
        for (int i = 0; i < 8; i++) begin
            din = VEC[i][4];
            cs = 0; cc = 0;
            step(int'(VEC[i][3:0]));
            if (VEC[i][4])
                chk(cs == 1 && cc == 0, "R1 rising edge pulses", cs * 10 + cc, 10);
            else
                chk(cs == 0 && cc == 1, "R1 falling edge pulses", cs * 10 + cc, 1);
            chk(dout == VEC[i][4], "R3 dout follows din", int'(dout), int'(VEC[i][4]));
            chk(i_dout == ~VEC[i][4], "R10 inverted dout", int'(i_dout), int'(~VEC[i][4]));
        end

        // R5 and R4: edge pulse then refresh spacing
        din = 1'b0;
        next_pulse(t0, s0);
        next_pulse(t1, s1);
        next_pulse(t2, s2);
        chk(t0 >= 0 && !s0, "R1 edge pulse on clear line", int'(s0), 0);
        chk(t1 - t0 == REFRESH, "R5 gap after edge pulse", t1 - t0, REFRESH);
        chk(t2 - t1 == REFRESH, "R4 refresh period", t2 - t1, REFRESH);
        chk(!s1 && !s2, "R4 refresh on matching line", int'(s1) + int'(s2), 0);

        // R6: open the loop, one hand pulse, then silence
        loop_on = 1'b0;
        bset = 1'b1;
        @(negedge clk);
        bset = 1'b0;
        chk(dout == 1'b1, "R3 hand set pulse", int'(dout), 1);
        k = 0;
        for (int j = 0; j < 2 * WDOG; j++) begin
            @(negedge clk);
            k++;
            if (lost) break;
        end
        chk(k == WDOG, "R6 watchdog interval", k, WDOG);
        chk(dout == 1'b0, "R6 default level", int'(dout), 0);

        // R7: recovery by a lone pulse
        bset = 1'b1;
        @(negedge clk);
        bset = 1'b0;
        chk(lost == 1'b0 && dout == 1'b1, "R7 recovery", int'(lost) * 10 + int'(dout), 1);
        chk(perr == 1'b0, "R8 no error before collision", int'(perr), 0);

        // R8: collision ignored, flag sticky
        bset = 1'b1; bclr = 1'b1;
        @(negedge clk);
        bset = 1'b0; bclr = 1'b0;
        chk(dout == 1'b1, "R8 collision keeps dout", int'(dout), 1);
        chk(perr == 1'b1, "R8 collision flagged", int'(perr), 1);
        bclr = 1'b1;
        @(negedge clk);
        bclr = 1'b0;
        chk(dout == 1'b0 && perr == 1'b1, "R8 error sticky", int'(dout) * 10 + int'(perr), 1);

        // R9: reset with low input sends a clear pulse
        loop_on = 1'b1;
        din = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(perr == 1'b0 && lost == 1'b1, "R9 reset clears flags", int'(perr) * 10 + int'(lost), 1);
        cs = 0; cc = 0;
        step(5);
        chk(cs == 0 && cc == 1, "R9 boot pulse on clear line", cs * 10 + cc, 1);
        chk(dout == 1'b0 && lost == 1'b0, "R9 boot low received", int'(dout) * 10 + int'(lost), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule